// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Unit

This block owns a 16-bit stack pointer and turns push and pop requests into a short series of byte accesses on a byte-wide memory port. A request names a direction (push or pop) and a size (one byte or a two-byte word). The unit works out the addresses, drives one byte access per clock, moves the stack pointer when the transfer completes, and pulses a completion strobe. Words are always stored with the high byte at the lower address, and the high byte is always the first byte accessed.

Two stack conventions are selectable per request through a mode input. In the empty-slot convention the pointer names the next free byte, so a push writes first and then steps down. In the full-slot convention the pointer names the most recently written byte, so a push steps down first and a pop reads at the pointer. The address arithmetic for words therefore differs between the two modes. A memory error reported during any byte access abandons the transfer, leaves the pointer where it was, and raises a fault flag that stays up until the next request is taken.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer output equals the SP_INIT parameter, and done, fault, the write strobe and the read strobe are all 0; the popped value output reads 0.
- R2: Empty-slot mode (modeLast=0), byte push: one write of wrData[7:0] at address SP; the pointer then becomes SP-1.
- R3: Empty-slot mode, word push: wrData[15:8] is written at SP-1, then wrData[7:0] at SP in the following clock; the pointer then becomes SP-2.
- R4: Empty-slot mode pops: a byte pop reads SP+1 and the pointer becomes SP+1; a word pop reads SP+1 (high byte) then SP+2 (low byte) and the pointer becomes SP+2.
- R5: Full-slot mode (modeLast=1), byte push: one write of wrData[7:0] at SP-1; the pointer then becomes SP-1.
- R6: Full-slot mode, word push: wrData[15:8] at SP-2, then wrData[7:0] at SP-1; the pointer then becomes SP-2.
- R7: Full-slot mode pops read at SP (and SP+1 for the low byte of a word) and the pointer grows by the size; popData is {high byte, low byte} for a word and {8'h00, byte} for a byte, and changes only when a pop completes.
- R8: A request seen at a clock edge while idle is taken at that edge; each byte access lasts exactly one clock, the first in the clock after the request edge, a word's second byte in the next; done is high for exactly one clock, the clock after the last access, in which the new pointer value is already visible.
- R9: memErr high during an access ends the transfer after that access: no done pulse, the pointer keeps its value, popData keeps its value, and fault is 1 from the next clock until the next request is taken (it reads 0 during that request's first access).
- R10: Pointer and address arithmetic wrap modulo 2^16, including a word whose two bytes straddle 16'hFFFF and 16'h0000.
- R11: Requests, mode, size and write data presented while a transfer is in progress have no effect on it; if reqPush and reqPop are both high when idle, the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqPush | input | 1 | Push request |
| reqPop | input | 1 | Pop request |
| wordSel | input | 1 | 1 = two-byte word, 0 = single byte |
| modeLast | input | 1 | 0 = pointer names next free byte, 1 = pointer names last used byte |
| wrData | input | 16 | Value to push (byte push uses bits 7:0) |
| memRdata | input | 8 | Read data from memory, valid in the access clock |
| memErr | input | 1 | Memory error for the current access |
| memAddr | output | 16 | Byte address of the current access |
| memWe | output | 1 | Write strobe for the current access |
| memRd | output | 1 | Read strobe for the current access |
| memWdata | output | 8 | Byte to be written |
| popData | output | 16 | Value delivered by the last completed pop |
| spOut | output | 16 | Current stack pointer |
| done | output | 1 | One-clock completion pulse |
| fault | output | 1 | Set by an aborted transfer |

## Verification
The embedded properties assume the memory answers inside the access clock, so read data and memErr belong to the address shown in that same clock, and that reset is held for at least one edge before any request. The stimulus drives every input on the falling edge and drops requests before the unit returns to idle, while deliberately holding noisy request, mode and data values during transfers to exercise the ignore rule. The pointer is started one above zero so that both modes' word transfers and pointer updates cross the 16-bit wrap point.

// File: rtl/spu_pkg.sv
package spu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } spu_state_e;

  // Strobes and latched request attributes from control to datapath.
  typedef struct packed {
    logic capture;  // request taken this clock
    logic access;   // a byte access is on the port
    logic second;   // the access is the second byte of a word
    logic opPush;   // latched direction
    logic opWord;   // latched size
    logic opLast;   // latched stack convention
    logic commit;   // last byte finished cleanly
    logic abort;    // memory error ends the transfer
  } spu_ctrl_t;

endpackage

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqPush,
  input  logic      reqPop,
  input  logic      wordSel,
  input  logic      modeLast,
  input  logic      memErr,
  output spu_ctrl_t ctl
);

  spu_state_e state, stateNext;
  logic opPush, opWord, opLast;
  logic isIdle, lastByte;

  assign isIdle   = (state == ST_IDLE);
  assign lastByte = (state == ST_SECOND) || ((state == ST_FIRST) && !opWord);

  always_comb begin
    ctl         = '0;
    ctl.capture = isIdle && (reqPush || reqPop);
    ctl.access  = !isIdle;
    ctl.second  = (state == ST_SECOND);
    ctl.opPush  = opPush;
    ctl.opWord  = opWord;
    ctl.opLast  = opLast;
    ctl.commit  = !isIdle && lastByte && !memErr;
    ctl.abort   = !isIdle && memErr;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqPush || reqPop) stateNext = ST_FIRST;
      ST_FIRST:  stateNext = (!memErr && opWord) ? ST_SECOND : ST_IDLE;
      ST_SECOND: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opPush <= 1'b0;
      opWord <= 1'b0;
      opLast <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.capture) begin
        opPush <= reqPush;   // push wins when both are raised
        opWord <= wordSel;
        opLast <= modeLast;
      end
    end
  end

  // R8: a second byte only ever follows a first byte access
  p_second_after_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SECOND) |-> ($past(state) == ST_FIRST));

  // R8 / R9: after the final or aborted access the unit is idle again
  p_idle_after_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit || ctl.abort) |=> (state == ST_IDLE));

  // R11: latched attributes hold for the whole transfer
  p_attr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SECOND) |-> ($stable(opPush) && $stable(opWord) && $stable(opLast)));

endmodule

// File: rtl/spu_dpath.sv
module spu_dpath
  import spu_pkg::*;
#(
  parameter int                 ADDR_W  = 16,
  parameter int                 BYTE_W  = 8,
  parameter logic [ADDR_W-1:0]  SP_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spu_ctrl_t             ctl,
  input  logic [2*BYTE_W-1:0]   wrData,
  input  logic [BYTE_W-1:0]     memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memWe,
  output logic                  memRd,
  output logic [BYTE_W-1:0]     memWdata,
  output logic [2*BYTE_W-1:0]   popData,
  output logic [ADDR_W-1:0]     spOut,
  output logic                  done,
  output logic                  fault
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] spReg, firstAddr, stepSize, spNext;
  logic [WORD_W-1:0] wrHold, popReg;
  logic [BYTE_W-1:0] rdHigh;
  logic              doneReg, faultReg;

  // First (lowest) address of the transfer; the second byte sits one above.
  always_comb begin
    unique case ({ctl.opLast, ctl.opPush, ctl.opWord})
      3'b010:  firstAddr = spReg;         // empty-slot, byte push
      3'b011:  firstAddr = spReg - ONE;   // empty-slot, word push
      3'b000,
      3'b001:  firstAddr = spReg + ONE;   // empty-slot, pops
      3'b110:  firstAddr = spReg - ONE;   // full-slot, byte push
      3'b111:  firstAddr = spReg - TWO;   // full-slot, word push
      default: firstAddr = spReg;         // full-slot, pops
    endcase
  end

  assign stepSize = ctl.opWord ? TWO : ONE;
  assign spNext   = ctl.opPush ? (spReg - stepSize) : (spReg + stepSize);

  assign memAddr  = ctl.second ? (firstAddr + ONE) : firstAddr;
  assign memWe    = ctl.access && ctl.opPush;
  assign memRd    = ctl.access && !ctl.opPush;
  assign memWdata = (ctl.opWord && !ctl.second) ? wrHold[WORD_W-1:BYTE_W]
                                                 : wrHold[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg    <= SP_INIT;
      wrHold   <= '0;
      popReg   <= '0;
      rdHigh   <= '0;
      doneReg  <= 1'b0;
      faultReg <= 1'b0;
    end else begin
      doneReg <= ctl.commit;
      if (ctl.capture) begin
        wrHold   <= wrData;
        faultReg <= 1'b0;
      end
      if (ctl.abort) faultReg <= 1'b1;
      if (ctl.access && !ctl.opPush && ctl.opWord && !ctl.second)
        rdHigh <= memRdata;
      if (ctl.commit) begin
        spReg <= spNext;
        if (!ctl.opPush)
          popReg <= ctl.opWord ? {rdHigh, memRdata} : {{BYTE_W{1'b0}}, memRdata};
      end
    end
  end

  assign popData = popReg;
  assign spOut   = spReg;
  assign done    = doneReg;
  assign fault   = faultReg;

  // R3 / R10: the second byte of a word is one above the first, modulo 2^16
  p_pair_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.second |-> (memAddr == $past(memAddr) + 1'b1));

  // R9: an aborted transfer leaves the pointer untouched
  p_sp_kept_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> (spReg == $past(spReg)));

  // R8: done is a single-clock pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |=> !doneReg);

  // R9: a fault never coincides with a completion
  p_fault_no_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultReg) |-> !doneReg);

  // R8: no access is driven in the completion clock, never both strobes
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> !(memWe || memRd));

  p_one_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRd));

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int                 ADDR_W  = 16,
  parameter int                 BYTE_W  = 8,
  parameter logic [ADDR_W-1:0]  SP_INIT = 16'h0100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqPush,
  input  logic                  reqPop,
  input  logic                  wordSel,
  input  logic                  modeLast,
  input  logic [2*BYTE_W-1:0]   wrData,
  input  logic [BYTE_W-1:0]     memRdata,
  input  logic                  memErr,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memWe,
  output logic                  memRd,
  output logic [BYTE_W-1:0]     memWdata,
  output logic [2*BYTE_W-1:0]   popData,
  output logic [ADDR_W-1:0]     spOut,
  output logic                  done,
  output logic                  fault
);

  spu_ctrl_t ctl;

  spu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqPush  (reqPush),
    .reqPop   (reqPop),
    .wordSel  (wordSel),
    .modeLast (modeLast),
    .memErr   (memErr),
    .ctl      (ctl)
  );

  spu_dpath #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .SP_INIT (SP_INIT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (wrData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memRd    (memRd),
    .memWdata (memWdata),
    .popData  (popData),
    .spOut    (spOut),
    .done     (done),
    .fault    (fault)
  );

endmodule

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/1ps
module tb_stack_ptr_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqPush = 1'b0, reqPop = 1'b0, wordSel = 1'b0, modeLast = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  memRdata;
  logic        memErr = 1'b0;
  logic [15:0] memAddr, popData, spOut;
  logic        memWe, memRd, done, fault;
  logic [7:0]  memWdata;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  logic [7:0] mem [64];
  logic [15:0] spM;
  logic [15:0] popM;

  always #4 clk = ~clk;

  stack_ptr_unit #(.SP_INIT(16'h0001)) dut (
    .clk(clk), .rstN(rstN), .reqPush(reqPush), .reqPop(reqPop),
    .wordSel(wordSel), .modeLast(modeLast), .wrData(wrData),
    .memRdata(memRdata), .memErr(memErr), .memAddr(memAddr),
    .memWe(memWe), .memRd(memRd), .memWdata(memWdata),
    .popData(popData), .spOut(spOut), .done(done), .fault(fault)
  );

  assign memRdata = mem[memAddr[5:0]];
  always @(posedge clk) if (memWe) mem[memAddr[5:0]] <= memWdata;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Stimulus vectors: {modeLast, push, word, errAt[1:0], data[15:0]}
  localparam int NVEC = 13;
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 2'd0, 16'hA1B2},  // R3 + R10 wrap below zero
    {1'b0, 1'b1, 1'b0, 2'd0, 16'h55C3},  // R2
    {1'b0, 1'b0, 1'b0, 2'd0, 16'h0000},  // R4 byte pop
    {1'b0, 1'b0, 1'b1, 2'd0, 16'h0000},  // R4 word pop, wrap upward
    {1'b1, 1'b1, 1'b1, 2'd0, 16'h1234},  // R6 straddling FFFF/0000
    {1'b1, 1'b1, 1'b0, 2'd0, 16'h9956},  // R5
    {1'b1, 1'b0, 1'b0, 2'd0, 16'h0000},  // R7 byte pop
    {1'b1, 1'b0, 1'b1, 2'd0, 16'h0000},  // R7 word pop straddling
    {1'b0, 1'b1, 1'b1, 2'd2, 16'hABCD},  // R9 error on second byte
    {1'b1, 1'b1, 1'b0, 2'd1, 16'h0011},  // R9 error on first byte
    {1'b0, 1'b1, 1'b0, 2'd0, 16'h0077},  // R2, fault clears
    {1'b1, 1'b0, 1'b1, 2'd0, 16'h0000},  // R7
    {1'b0, 1'b0, 1'b1, 2'd0, 16'h0000}   // R4
  };

  task automatic doOp(input logic lst, input logic psh, input logic wrd,
                      input logic [1:0] errAt, input logic [15:0] dat, input logic both);
    logic [15:0] a0, a1, newSp, expPop;
    int nb;
    nb = wrd ? 2 : 1;
    if (!lst) a0 = psh ? (wrd ? spM - 16'd1 : spM) : spM + 16'd1;
    else      a0 = psh ? (spM - (wrd ? 16'd2 : 16'd1)) : spM;
    a1 = a0 + 16'd1;
    newSp = psh ? spM - 16'(nb) : spM + 16'(nb);
    expPop = wrd ? {mem[a0[5:0]], mem[a1[5:0]]} : {8'h00, mem[a0[5:0]]};

    @(negedge clk);
    modeLast = lst; wordSel = wrd; wrData = dat;
    reqPush = psh | both; reqPop = !psh | both;
    @(negedge clk);
    // Noise while busy (R11): must be ignored
    modeLast = !lst; wordSel = !wrd; wrData = ~dat; reqPush = 1'b1; reqPop = 1'b1;
    for (int k = 0; k < nb; k++) begin
      logic [15:0] ea;
      logic [7:0]  ed;
      ea = (k == 0) ? a0 : a1;
      ed = (wrd && k == 0) ? dat[15:8] : dat[7:0];
      if (k == 0) chk(fault == 1'b0, "R9 fault cleared on new request", 32'(fault), 32'd0);
      chk(memAddr == ea, lst ? "R5/R6/R7 address" : "R2/R3/R4 address", 32'(memAddr), 32'(ea));
      chk(memWe == psh && memRd == !psh, "R8 strobe direction", {memWe, memRd}, {psh, !psh});
      if (psh) chk(memWdata == ed, "R3/R6 write byte order", 32'(memWdata), 32'(ed));
      if (errAt == 2'(k + 1)) memErr = 1'b1;
      @(negedge clk);
      memErr = 1'b0;
      if (errAt == 2'(k + 1)) begin
        reqPush = 1'b0; reqPop = 1'b0;
        chk(done == 1'b0, "R9 no done on abort", 32'(done), 32'd0);
        chk(fault == 1'b1, "R9 fault raised", 32'(fault), 32'd1);
        chk(spOut == spM, "R9 sp unchanged", 32'(spOut), 32'(spM));
        chk(popData == popM, "R9 popData unchanged", 32'(popData), 32'(popM));
        return;
      end
    end
    reqPush = 1'b0; reqPop = 1'b0;
    spM = newSp;
    if (!psh) popM = expPop;
    chk(done == 1'b1, "R8 done after last byte", 32'(done), 32'd1);
    chk(spOut == spM, "R10 sp update", 32'(spOut), 32'(spM));
    chk(popData == popM, "R7 popped value", 32'(popData), 32'(popM));
    @(negedge clk);
    chk(done == 1'b0 && !memWe && !memRd, "R11 idle after done", {done, memWe, memRd}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    spM = 16'h0001;
    popM = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(spOut == 16'h0001, "R1 reset sp", 32'(spOut), 32'h1);
    chk(!done && !fault && !memWe && !memRd, "R1 reset flags", {done, fault, memWe, memRd}, 32'd0);
    chk(popData == 16'h0000, "R1 reset popData", 32'(popData), 32'd0);

    for (int v = 0; v < NVEC; v++)
      doOp(VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17:16], VEC[v][15:0], 1'b0);

    // R11: both requests together, push wins (empty-slot byte)
    doOp(1'b0, 1'b1, 1'b0, 2'd0, 16'h0099, 1'b1);
    // R9: pop aborted on its first byte keeps popData
    doOp(1'b1, 1'b0, 1'b1, 2'd1, 16'h0000, 1'b0);
    // R9: recovery pop after fault
    doOp(1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule